// File: doc/BRIEF.md
# Fuse Array Read Controller

This block sits between a host register bus and a small one-time-programmable fuse array of 32 blocks, each 16 bits wide (64 bytes in all). Software reads one block at a time through a fixed handshake. It first waits for the standby flag. It then writes the block number, writes a read-start pulse, and polls a sticky done flag. Once the flag is set it takes the block from the read-data register and writes a clear pulse to drop the flag. Software picks a single byte by shifting the returned word right by 8 times (byte offset mod 2).

The controller runs only while an external module-enable input is high. If the enable falls, any read in flight is dropped, the controller goes back to idle, and standby reads low. Programming is not implemented. The program-start bit is accepted and discarded, and the protect flag always reads 1.

The fuse array is reached through a request channel and a response strobe. The request channel is valid/ready. After `fz_req_valid` rises, it stays high and `fz_req_idx` stays constant until a cycle in which `fz_req_ready` is high; the array may hold ready low for any number of cycles. The response channel has no ready, because the controller is always able to take the one response it is waiting for. A response that comes in when no read is waiting is ignored.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: Register offsets: 0x04 read data, 0x08 write data, 0x0C block index, 0x10 mode control, 0x14 status; 0x00 and mode control read as zero. Reset clears index, done flag and read data; with enable high, status then reads 0x0C.
- R2: The block index register keeps only write-data bits [4:0]; its upper bits read as zero.
- R3: Writing mode control with bit 1 set while in standby starts a read of the current index. While the read runs, status bit 1 (read busy) is 1 and bit 2 (standby) is 0.
- R4: The returned 16-bit block is placed zero-extended in the read-data register, status bit 4 (done) is set, and the controller returns to standby (status 0x1C).
- R5: The done flag stays set until a write to mode control with bit 2 set; after that write, status reads 0x0C.
- R6: A read-start issued while not in standby is ignored: it starts no further fuse request.
- R7: With enable low, status reads 0x08 and mode-control pulses have no effect. Dropping enable during a read abandons it, and its late response leaves the read data and the done flag unchanged.
- R8: A fuse request keeps valid high and its index constant until accepted by ready.
- R9: Status bit 3 (protect) always reads 1. Mode-control bit 0 (program start) changes nothing, and status bit 0 stays 0.
- R10: The write-data register at 0x08 reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_en | input | 1 | External module enable |
| bus_addr | input | 5 | Register byte address |
| bus_we | input | 1 | Register write enable |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from address) |
| fz_req_valid | output | 1 | Fuse request valid |
| fz_req_ready | input | 1 | Fuse request ready |
| fz_req_idx | output | 5 | Block number requested |
| fz_rsp_valid | input | 1 | Fuse response strobe |
| fz_rsp_data | input | 16 | Fuse block contents |

## Verification
Plain reads cover the first, last and two middle blocks. The block pattern differs at every index, so a wrong index latch or a dropped bit shows up as a data mismatch. A second start during a busy read separates "start ignored" from "request issued twice". Holding the array's ready low separates a held request from one that drops or changes its index. Dropping the enable both before and after the request is accepted separates abandoning a read from finishing it with a stale response.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  // register byte offsets
  localparam int unsigned OFS_GCTL = 'h00;
  localparam int unsigned OFS_RDAT = 'h04;
  localparam int unsigned OFS_WDAT = 'h08;
  localparam int unsigned OFS_IDX  = 'h0C;
  localparam int unsigned OFS_MODE = 'h10;
  localparam int unsigned OFS_STAT = 'h14;

  // mode control pulse bits
  localparam int unsigned MODE_PGM = 0;
  localparam int unsigned MODE_RD  = 1;
  localparam int unsigned MODE_CLR = 2;

  // status bits
  localparam int unsigned ST_PGM   = 0;
  localparam int unsigned ST_RBUSY = 1;
  localparam int unsigned ST_STBY  = 2;
  localparam int unsigned ST_PROT  = 3;
  localparam int unsigned ST_DONE  = 4;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_REQ  = 2'd1,
    RD_WAIT = 2'd2
  } rd_state_e;
endpackage

// File: rtl/fuse_reg_file.sv
module fuse_reg_file
  import fuse_rd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [IDX_W-1:0]  idx_q,
  output logic [DATA_W-1:0] wdat_q,
  output logic              rd_pulse,
  output logic              clr_pulse
);
  logic hit_idx, hit_wdat, hit_mode;

  always_comb begin
    hit_idx  = bus_we && (bus_addr == ADDR_W'(OFS_IDX));
    hit_wdat = bus_we && (bus_addr == ADDR_W'(OFS_WDAT));
    hit_mode = bus_we && (bus_addr == ADDR_W'(OFS_MODE)) && mod_en;
  end

  // mode control is write-only: each set bit is a one-cycle pulse.
  // The program-start bit is decoded nowhere and therefore discarded.
  always_comb begin
    rd_pulse  = hit_mode && bus_wdata[MODE_RD];
    clr_pulse = hit_mode && bus_wdata[MODE_CLR];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      wdat_q <= '0;
    end else begin
      if (hit_idx)  idx_q  <= bus_wdata[IDX_W-1:0];
      if (hit_wdat) wdat_q <= bus_wdata;
    end
  end
endmodule

// File: rtl/fuse_rd_fsm.sv
module fuse_rd_fsm
  import fuse_rd_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int BLK_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en,
  input  logic             rd_pulse,
  input  logic             clr_pulse,
  input  logic [IDX_W-1:0] idx_in,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [IDX_W-1:0] req_idx,
  input  logic             rsp_valid,
  input  logic [BLK_W-1:0] rsp_data,
  output logic             busy,
  output logic             standby,
  output logic             done,
  output logic [BLK_W-1:0] blk
);
  rd_state_e        state_q;
  logic [IDX_W-1:0] req_idx_q;
  logic [BLK_W-1:0] blk_q;
  logic             done_q;
  logic             rsp_take;

  always_comb rsp_take = mod_en && (state_q == RD_WAIT) && rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= RD_IDLE;
      req_idx_q <= '0;
      blk_q     <= '0;
    end else if (!mod_en) begin
      state_q <= RD_IDLE;
    end else begin
      unique case (state_q)
        RD_IDLE: if (rd_pulse) begin
          req_idx_q <= idx_in;
          state_q   <= RD_REQ;
        end
        RD_REQ:  if (req_ready) state_q <= RD_WAIT;
        RD_WAIT: if (rsp_valid) begin
          blk_q   <= rsp_data;
          state_q <= RD_IDLE;
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  // sticky completion flag: set by an accepted response, cleared only by pulse
  always_ff @(posedge clk) begin
    if (!rst_n)         done_q <= 1'b0;
    else if (rsp_take)  done_q <= 1'b1;
    else if (clr_pulse) done_q <= 1'b0;
  end

  always_comb begin
    req_valid = mod_en && (state_q == RD_REQ);
    req_idx   = req_idx_q;
    busy      = (state_q != RD_IDLE);
    standby   = mod_en && (state_q == RD_IDLE);
    done      = done_q;
    blk       = blk_q;
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> !mod_en || (req_valid && $stable(req_idx)));

  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !clr_pulse |=> done_q);

  // R4
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(rsp_valid));

  // R6
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse && !standby |=> $stable(req_idx_q));

  // R7
  dis_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_en) |=> !busy && !req_valid);
endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
  import fuse_rd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int BLOCKS = 32,
  parameter int BLK_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mod_en,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_we,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       fz_req_valid,
  input  logic                       fz_req_ready,
  output logic [$clog2(BLOCKS)-1:0]  fz_req_idx,
  input  logic                       fz_rsp_valid,
  input  logic [BLK_W-1:0]           fz_rsp_data
);
  localparam int IDX_W = $clog2(BLOCKS);

  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] wdat_q;
  logic              rd_pulse, clr_pulse;
  logic              busy, standby, done;
  logic [BLK_W-1:0]  blk;
  logic [DATA_W-1:0] status;

  fuse_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
    .clk, .rst_n, .mod_en, .bus_addr, .bus_we, .bus_wdata,
    .idx_q, .wdat_q, .rd_pulse, .clr_pulse
  );

  fuse_rd_fsm #(.IDX_W(IDX_W), .BLK_W(BLK_W)) u_fsm (
    .clk, .rst_n, .mod_en, .rd_pulse, .clr_pulse, .idx_in(idx_q),
    .req_valid(fz_req_valid), .req_ready(fz_req_ready), .req_idx(fz_req_idx),
    .rsp_valid(fz_rsp_valid), .rsp_data(fz_rsp_data),
    .busy, .standby, .done, .blk
  );

  always_comb begin
    status           = '0;
    status[ST_PGM]   = 1'b0;
    status[ST_RBUSY] = busy;
    status[ST_STBY]  = standby;
    status[ST_PROT]  = 1'b1;
    status[ST_DONE]  = done;
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(OFS_RDAT): bus_rdata = DATA_W'(blk);
      ADDR_W'(OFS_WDAT): bus_rdata = wdat_q;
      ADDR_W'(OFS_IDX):  bus_rdata = DATA_W'(idx_q);
      ADDR_W'(OFS_STAT): bus_rdata = status;
      default:           bus_rdata = '0;
    endcase
  end

  // R3
  busy_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[ST_RBUSY] && status[ST_STBY]));

  // R9
  pgm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status[ST_PGM] && status[ST_PROT]);
endmodule

// File: tb/sim_fuse_rd_ctrl.sv
`timescale 1ns/1ps
module sim_fuse_rd_ctrl;
  localparam int ARR_LAT = 4;
  localparam logic [4:0] A_GCTL = 5'h00, A_RDAT = 5'h04, A_WDAT = 5'h08,
                         A_IDX = 5'h0C, A_MODE = 5'h10, A_STAT = 5'h14;

  logic        clk = 0, rst_n = 0, mod_en = 1;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        fz_req_valid, fz_req_ready, fz_rsp_valid = 0;
  logic [4:0]  fz_req_idx;
  logic [15:0] fz_rsp_data = '0;
  logic        bp = 0;

  int checks = 0, errors = 0, req_cnt = 0;
  logic [4:0] exp_q[$];

  always #2.5 clk = ~clk;
  assign fz_req_ready = !bp;

  fuse_rd_ctrl u0 (.*);

  function automatic logic [15:0] fz(input logic [4:0] i);
    return 16'h5A3C ^ {i, i, i[3:0], 2'b01};
  endfunction

  // array model plus monitor: pops the expected index at each accepted request
  int pend = 0;
  logic [4:0] pend_idx = '0;
  always @(posedge clk) begin
    fz_rsp_valid <= 1'b0;
    if (pend > 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        fz_rsp_valid <= 1'b1;
        fz_rsp_data  <= fz(pend_idx);
      end
    end
    if (rst_n && fz_req_valid && fz_req_ready) begin
      req_cnt++;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected request act=%0d exp=none", fz_req_idx);
      end else begin
        logic [4:0] e;
        e = exp_q.pop_front();
        if (fz_req_idx !== e) begin
          errors++;
          $display("FAIL R3 request index act=%0d exp=%0d", fz_req_idx, e);
        end
      end
      pend     <= ARR_LAT;
      pend_idx <= fz_req_idx;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 0;
    #1 d = bus_rdata;
  endtask

  task automatic poll_done(output logic [31:0] s);
    for (int k = 0; k < 200; k++) begin
      rd(A_STAT, s);
      if (s[4]) break;
    end
  endtask

  task automatic do_read(input logic [4:0] idx);
    logic [31:0] v;
    wr(A_IDX, 32'(idx));
    exp_q.push_back(idx);
    wr(A_MODE, 32'h2);
    rd(A_STAT, v);
    check("R3 busy status", v & 32'h6, 32'h2);
    poll_done(v);
    check("R4 done status", v, 32'h1C);
    rd(A_RDAT, v);
    check("R4 read data", v, {16'h0, fz(idx)});
    repeat (5) @(negedge clk);
    rd(A_STAT, v);
    check("R5 done sticky", v, 32'h1C);
    wr(A_MODE, 32'h4);
    rd(A_STAT, v);
    check("R5 done cleared", v, 32'h0C);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(A_STAT, v); check("R1 reset status", v, 32'h0C);
    rd(A_RDAT, v); check("R1 reset read data", v, 32'h0);
    rd(A_IDX, v);  check("R1 reset index", v, 32'h0);
    rd(A_GCTL, v); check("R1 offset 0x00 reads zero", v, 32'h0);

    wr(A_WDAT, 32'hDEADBEEF);
    rd(A_WDAT, v); check("R10 write data readback", v, 32'hDEADBEEF);
    rd(A_MODE, v); check("R1 mode reads zero", v, 32'h0);

    wr(A_IDX, 32'hFFFF_FFE5);
    rd(A_IDX, v); check("R2 index masked", v, 32'h05);

    do_read(5'd0);
    do_read(5'd31);
    do_read(5'd17);
    do_read(5'd10);

    // R6: second start while busy
    n = req_cnt;
    wr(A_IDX, 32'd3);
    exp_q.push_back(5'd3);
    wr(A_MODE, 32'h2);
    wr(A_IDX, 32'd9);
    wr(A_MODE, 32'h2);
    poll_done(v);
    repeat (10) @(negedge clk);
    check("R6 one request only", 32'(req_cnt - n), 32'd1);
    rd(A_RDAT, v); check("R6 data of first start", v, {16'h0, fz(5'd3)});
    wr(A_MODE, 32'h4);

    // R8: back-pressure
    bp = 1;
    wr(A_IDX, 32'd21);
    exp_q.push_back(5'd21);
    wr(A_MODE, 32'h2);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R8 request held", {26'h0, fz_req_valid, fz_req_idx}, {26'h0, 1'b1, 5'd21});
    end
    bp = 0;
    poll_done(v);
    rd(A_RDAT, v); check("R8 data after stall", v, {16'h0, fz(5'd21)});
    wr(A_MODE, 32'h4);

    // R9: program start is inert
    wr(A_MODE, 32'h1);
    rd(A_STAT, v); check("R9 status after program start", v, 32'h0C);
    do_read(5'd10);

    // R7: enable low
    mod_en = 0;
    @(negedge clk);
    rd(A_STAT, v); check("R7 disabled status", v, 32'h08);
    n = req_cnt;
    wr(A_MODE, 32'h2);
    repeat (10) @(negedge clk);
    mod_en = 1;
    repeat (10) @(negedge clk);
    check("R7 start ignored while disabled", 32'(req_cnt - n), 32'd0);
    rd(A_STAT, v); check("R7 standby after enable", v, 32'h0C);

    // R7: drop before acceptance
    bp = 1;
    wr(A_IDX, 32'd7);
    wr(A_MODE, 32'h2);
    repeat (2) @(negedge clk);
    mod_en = 0;
    @(negedge clk);
    check("R7 request withdrawn", {31'h0, fz_req_valid}, 32'h0);
    rd(A_STAT, v); check("R7 abandoned status", v, 32'h08);
    mod_en = 1; bp = 0;
    repeat (5) @(negedge clk);
    check("R7 no late request", 32'(req_cnt - n), 32'd0);

    // R7: drop after acceptance, late response discarded
    wr(A_IDX, 32'd12);
    exp_q.push_back(5'd12);
    wr(A_MODE, 32'h2);
    @(negedge clk);
    mod_en = 0;
    repeat (10) @(negedge clk);
    mod_en = 1;
    @(negedge clk);
    rd(A_STAT, v); check("R7 no done from late response", v, 32'h0C);
    rd(A_RDAT, v); check("R7 read data kept", v, {16'h0, fz(5'd10)});

    do_read(5'd22);
    check("R3 expected queue drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule